// File: doc/BRIEF.md
# External Clock Divider Timer

This block divides a slow clock arriving on an input pin and sends the result back out on a pin. Two flops bring the pin into the system clock domain. An edge detector then turns the chosen transition of the pin into a count pulse that lasts one cycle. An 8-bit counter advances on each count pulse and is compared against a programmable reference value. On a match the counter returns to zero and an output flip-flop toggles. The output flip-flop therefore runs at the input edge rate divided by 2 × (reference + 1).

Software sets up the block through a small write port that holds three registers: the reference value, the mode and the output enable. The divided clock reaches the pin only through a gate. The gate passes the toggle flop while the output enable is set, and it ORs in the port output latch, so the latch must be 0 for the divided clock to show. The port direction bit drives the pin's output enable.

Top module: `tcd_ext_divider`

## Requirements
- R1: After reset, the counter, reference, mode, output enable and toggle flop are all zero, so `clk_out_o` is low.
- R2: A write with `wr_en_i`=1 updates one register, chosen by `wr_addr_i`: 0 is the reference (all data bits), 1 is the mode, 2 is the output enable (data bit 0).
- R3: The input pin passes through a two-flop synchronizer. With a reference of 0 and the output enabled, the pin output changes on the third rising system clock edge after the input transition, and not earlier.
- R4: Mode bits [5:4] select the counted edge: 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both edges.
- R5: Count pulses occur only while mode bit 6 is 0 (the input pin is the count source) and mode bit 2 is 1 (run). In any other case the counter and the toggle flop hold their values.
- R6: On a count pulse, if the counter equals the reference, the counter clears and the toggle flop inverts. Otherwise the counter increments. A reference of 1 with rising-edge counting gives one quarter of the input frequency.
- R7: A mode write with data bit 3 set clears the counter and the toggle flop in the same cycle. This clear takes priority over a count pulse.
- R8: `clk_out_o` equals (toggle flop AND output enable) OR `port_latch_i`, and `clk_out_oe_o` follows `port_dir_i`.
- R9: While the output enable and the port latch are both 0, `clk_out_o` stays low even while counting runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| ext_clk_i | input | 1 | External count clock, asynchronous to clk_i |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| port_latch_i | input | 1 | Port output latch |
| clk_out_o | output | 1 | Divided clock pin value |
| clk_out_oe_o | output | 1 | Pin output enable |

## Verification
The assertions check on every cycle that the counter wraps and the flop toggles only on a match, that the counter increments by exactly one otherwise, that state holds when there is no pulse, that the clear has priority, and that pulses appear only in run mode with the external source selected. The assertions cannot show the division ratios for each edge code, the exact synchronizer latency or the pin gating as seen at the ports. The bench shows these by counting output toggles over known input bursts and by timing single transitions.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [1:0] {
    REG_REF   = 2'd0,
    REG_MODE  = 2'd1,
    REG_OUTEN = 2'd2
  } reg_sel_e;

  localparam int MODE_SRC_BIT  = 6;
  localparam int MODE_EDGE_HI  = 5;
  localparam int MODE_EDGE_LO  = 4;
  localparam int MODE_CLR_BIT  = 3;
  localparam int MODE_RUN_BIT  = 2;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;

  typedef struct packed {
    logic       src;
    logic [1:0] edge_sel;
    logic       run;
  } mode_t;
endpackage

// File: rtl/tcd_regs.sv
module tcd_regs
  import tcd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ref_o,
  output mode_t             mode_o,
  output logic              oe_o,
  output logic              clr_o
);
  logic [DATA_W-1:0] ref_q;
  mode_t             mode_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      mode_q <= '0;
      oe_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_addr_i))
        REG_REF:   ref_q <= wr_data_i;
        REG_MODE: begin
          mode_q.src      <= wr_data_i[MODE_SRC_BIT];
          mode_q.edge_sel <= wr_data_i[MODE_EDGE_HI:MODE_EDGE_LO];
          mode_q.run      <= wr_data_i[MODE_RUN_BIT];
        end
        REG_OUTEN: oe_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // clear is an action, not stored state
  assign clr_o  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_MODE) && wr_data_i[MODE_CLR_BIT];
  assign ref_o  = ref_q;
  assign mode_o = mode_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/tcd_edge_sync.sv
module tcd_edge_sync
  import tcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic       en_i,
  input  logic [1:0] edge_sel_i,
  output logic       pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sampled;
  logic                   rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sampled;
    end
  end

  assign sampled = sync_q[SYNC_STAGES-1];
  assign rise    = sampled & ~prev_q;
  assign fall    = ~sampled & prev_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: pulse_o = en_i & rise;
      EDGE_FALL: pulse_o = en_i & fall;
      default:   pulse_o = en_i & (rise | fall);
    endcase
  end

  // R4: a pulse always marks a real transition of the synchronized input
  a_r4_pulse_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (sampled != prev_q));
endmodule

// File: rtl/tcd_count.sv
module tcd_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic             tff_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             tff_q;
  logic             hit;

  assign hit = (cnt_q == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tff_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tff_q <= 1'b0;
    end else if (pulse_i) begin
      if (hit) begin
        cnt_q <= '0;
        tff_q <= ~tff_q;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign tff_o = tff_q;

  a_r6_match_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !clr_i && cnt_q == ref_i) |=> (cnt_q == '0 && tff_q != $past(tff_q)));

  a_r6_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !clr_i && cnt_q != ref_i) |=> (cnt_q == $past(cnt_q) + ONE && $stable(tff_q)));

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !clr_i) |=> ($stable(cnt_q) && $stable(tff_q)));

  a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !tff_q));
endmodule

// File: rtl/tcd_pin_gate.sv
module tcd_pin_gate (
  input  logic tff_i,
  input  logic oe_i,
  input  logic latch_i,
  input  logic dir_i,
  output logic pin_o,
  output logic pin_oe_o
);
  assign pin_o    = (tff_i & oe_i) | latch_i;
  assign pin_oe_o = dir_i;
endmodule

// File: rtl/tcd_ext_divider.sv
module tcd_ext_divider
  import tcd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_clk_i,
  input  logic             port_dir_i,
  input  logic             port_latch_i,
  output logic             clk_out_o,
  output logic             clk_out_oe_o
);
  logic [CNT_W-1:0] ref_val;
  mode_t            mode;
  logic             oe;
  logic             clr;
  logic             cnt_en;
  logic             cnt_pulse;
  logic             tff;

  tcd_regs #(.DATA_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ref_o     (ref_val),
    .mode_o    (mode),
    .oe_o      (oe),
    .clr_o     (clr)
  );

  assign cnt_en = mode.run & ~mode.src;

  tcd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_clk_i),
    .en_i       (cnt_en),
    .edge_sel_i (mode.edge_sel),
    .pulse_o    (cnt_pulse)
  );

  tcd_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (cnt_pulse),
    .clr_i   (clr),
    .ref_i   (ref_val),
    .tff_o   (tff)
  );

  tcd_pin_gate u_gate (
    .tff_i    (tff),
    .oe_i     (oe),
    .latch_i  (port_latch_i),
    .dir_i    (port_dir_i),
    .pin_o    (clk_out_o),
    .pin_oe_o (clk_out_oe_o)
  );

  a_r5_gated_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_pulse |-> (mode.run && !mode.src));
endmodule

// File: tb/tb_tcd_ext_divider.sv
module tb_tcd_ext_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ext_clk_i = 1'b0;
  logic       port_dir_i = 1'b1;
  logic       port_latch_i = 1'b0;
  logic       clk_out_o, clk_out_oe_o;

  tcd_ext_divider dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ext_clk_i(ext_clk_i), .port_dir_i(port_dir_i),
    .port_latch_i(port_latch_i), .clk_out_o(clk_out_o), .clk_out_oe_o(clk_out_oe_o)
  );

  always #5 clk_i = ~clk_i;

  int   n_chk = 0, n_fail = 0, toggles = 0;
  logic last_out = 1'b0;
  bit   done = 1'b0;

  always @(negedge clk_i) begin
    if (clk_out_o !== last_out) toggles <= toggles + 1;
    last_out <= clk_out_o;
  end

  typedef struct packed {
    logic [7:0] refv;
    logic [1:0] esel;
    logic [7:0] ncyc;
    logic [7:0] expt;
  } vec_t;

  // expected = pulses / (ref+1), pulses = ncyc or 2*ncyc for both-edge codes
  localparam vec_t VECS [7] = '{
    '{8'd1, 2'b00, 8'd8,  8'd4},
    '{8'd0, 2'b00, 8'd5,  8'd5},
    '{8'd2, 2'b01, 8'd9,  8'd3},
    '{8'd1, 2'b10, 8'd4,  8'd4},
    '{8'd3, 2'b11, 8'd6,  8'd3},
    '{8'd4, 2'b00, 8'd12, 8'd2},
    '{8'd2, 2'b10, 8'd3,  8'd2}
  };

  function automatic logic [7:0] mode_word(logic src, logic [1:0] esel, logic clr, logic run);
    return {1'b0, src, esel, clr, run, 2'b00};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_ext(int n, output int seen);
    int base;
    #1 base = toggles;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ext_clk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    repeat (6) @(negedge clk_i);
    #1 seen = toggles - base;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk_i);
    chk(clk_out_o == 1'b0, "R1", clk_out_o, 0);
    chk(clk_out_oe_o == 1'b1, "R8", clk_out_oe_o, 1);
    rst_ni = 1'b1;
    // R1: enabling output only shows the reset-cleared toggle flop
    wr(2'd2, 8'h01);
    #1 chk(clk_out_o == 1'b0, "R1", clk_out_o, 0);

    // vector table: R2 R4 R6
    foreach (VECS[i]) begin
      wr(2'd0, VECS[i].refv);
      wr(2'd1, mode_word(1'b0, VECS[i].esel, 1'b1, 1'b1));
      run_ext(int'(VECS[i].ncyc), seen);
      chk(seen == int'(VECS[i].expt), "R6/R4 ratio", seen, int'(VECS[i].expt));
    end

    // R6: ref 1 rising -> quarter frequency: 4 input cycles give one full output period
    wr(2'd0, 8'd1);
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b1));
    run_ext(4, seen);
    chk(seen == 2, "R6 quarter", seen, 2);

    // R3 latency
    wr(2'd0, 8'd0);
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b1));
    @(negedge clk_i); ext_clk_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); #1 chk(clk_out_o == 1'b0, "R3 early", clk_out_o, 0);
    @(negedge clk_i); #1 chk(clk_out_o == 1'b1, "R3 third edge", clk_out_o, 1);
    ext_clk_i = 1'b0;
    repeat (6) @(negedge clk_i);

    // R7 clear with flop high
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b1));
    #1 chk(clk_out_o == 1'b0, "R7 clear flop", clk_out_o, 0);
    // R7 clear mid-count
    wr(2'd0, 8'd1);
    run_ext(1, seen);
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b1));
    run_ext(1, seen);
    chk(seen == 0, "R7 counter cleared", seen, 0);
    run_ext(1, seen);
    chk(seen == 1, "R7 count resumes", seen, 1);

    // R5 run bit off, then source bit set
    wr(2'd0, 8'd0);
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b0));
    run_ext(5, seen);
    chk(seen == 0, "R5 run off", seen, 0);
    wr(2'd1, mode_word(1'b1, 2'b10, 1'b1, 1'b1));
    run_ext(5, seen);
    chk(seen == 0, "R5 internal source", seen, 0);

    // R8 / R2 output enable register and latch
    wr(2'd1, mode_word(1'b0, 2'b00, 1'b1, 1'b1));
    run_ext(1, seen);
    #1 chk(clk_out_o == 1'b1, "R8 flop passes", clk_out_o, 1);
    wr(2'd2, 8'h00);
    #1 chk(clk_out_o == 1'b0, "R2 oe write", clk_out_o, 0);
    port_latch_i = 1'b1;
    #1 chk(clk_out_o == 1'b1, "R8 latch high", clk_out_o, 1);
    port_latch_i = 1'b0;
    port_dir_i = 1'b0;
    #1 chk(clk_out_oe_o == 1'b0, "R8 direction", clk_out_oe_o, 0);
    port_dir_i = 1'b1;

    // R9 counting with oe=0, latch=0
    run_ext(6, seen);
    chk(seen == 0, "R9 no toggles", seen, 0);
    chk(clk_out_o == 1'b0, "R9 pin low", clk_out_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule